// File: doc/BRIEF.md
# Write-Once Clock Mode Register

This block is the 8-bit clock mode register of a small microcontroller. A bus master writes it with plain byte writes or with single-bit set/clear accesses from read-modify-write instructions. Its fields drive the clock system: the division ratio and source selection, on/off control for the main and ring oscillators, the choice between a ceramic and an RC main oscillator, a double-speed request and an operating-mode bit. The oscillators and the clock multiplexer sit outside. This block only produces their control levels, the register read-back and a lock flag.

Three bits are guarded against a runaway program: bit 5 (oscillator type), bit 1 (double speed) and bit 0 (operating mode). Together they are the protected set. Only the first access after reset can change them. Every access sets the lock: a plain write of any value, or a bit set/clear aimed at any bit. Once the lock is set, the protected bits hold until the next reset. The other five bits stay writable. The block also blocks double speed whenever the RC oscillator is selected.

Top module: `clk_mode_reg`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) loads the register with 8'h80 and clears the lock. Bits 7:6 = 2'b10 select the ring oscillator as clock source. The reset value and the lock status are visible from the next edge.
- R2: A plain write (`wrEn` high) made while unlocked loads all eight bits from `wrData` and sets the lock. Both results are visible after that edge.
- R3: While locked, a plain write leaves bits 5, 1 and 0 unchanged and still loads bits 7, 6, 4, 3 and 2 from the same write.
- R4: A bit access (`bitOpEn` high, `wrEn` low) aimed at bit 2, 3, 4, 6 or 7 sets that bit when `bitOpSet` is 1 and clears it when `bitOpSet` is 0. The target is given by `bitOpIdx`. No other bit changes, and the access sets the lock.
- R5: A bit access aimed at bit 5, 1 or 0 changes that bit only while unlocked, and it sets the lock. While locked, such an access leaves the register unchanged.
- R6: `dblSpeed` is high only when bit 1 is 1 and bit 5 is 0 (bit 5 = 1 means RC oscillator, 0 means ceramic).
- R7: The field outputs follow the register bits: `divSel` = bits 7:6, `mainOscOff` = bit 4, `ringOscOff` = bit 3, `auxBit` = bit 2, `rcSel` = bit 5, `modeBit` = bit 0.
- R8: When `wrEn` and `bitOpEn` are high in the same cycle, only the plain write takes effect.
- R9: `rdData` always shows the present register value and `lockStatus` the present lock flag. Each reflects an update right after the edge that made it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Plain byte write strobe |
| wrData | input | 8 | Data for plain write |
| bitOpEn | input | 1 | Single-bit set/clear strobe |
| bitOpSet | input | 1 | 1 = set, 0 = clear the addressed bit |
| bitOpIdx | input | 3 | Addressed bit for a bit access |
| rdData | output | 8 | Register read-back |
| lockStatus | output | 1 | Protected bits locked |
| divSel | output | 2 | Clock division / source select (bits 7:6) |
| mainOscOff | output | 1 | Main oscillator stop (bit 4) |
| ringOscOff | output | 1 | Ring oscillator stop (bit 3) |
| auxBit | output | 1 | Free general bit (bit 2) |
| rcSel | output | 1 | 1 = RC, 0 = ceramic main oscillator (bit 5) |
| dblSpeed | output | 1 | Double-speed enable, gated off under RC |
| modeBit | output | 1 | Operating-mode bit (bit 0) |

## Verification
All state is visible at the ports, so any wrong register bit or lock flag shows on `rdData` or `lockStatus` at the first edge after the access that caused it. One case behaves differently: a lock that fails to set shows no difference until a later access tries to change a protected bit. The stimulus therefore pairs every first access with later attempts on bits 5, 1 and 0, including bit accesses aimed at the free bits. A behavioural model is compared with every output on every cycle, so a divergence is reported in the cycle it appears.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned IDX_W = $clog2(REG_W);

  localparam logic [REG_W-1:0] PROT_MASK = 8'b0010_0011;
  localparam logic [REG_W-1:0] RESET_VAL = 8'b1000_0000;

  localparam int unsigned B_DIV_HI   = 7;
  localparam int unsigned B_DIV_LO   = 6;
  localparam int unsigned B_SRC_RC   = 5;
  localparam int unsigned B_MAIN_OFF = 4;
  localparam int unsigned B_RING_OFF = 3;
  localparam int unsigned B_AUX      = 2;
  localparam int unsigned B_DBL      = 1;
  localparam int unsigned B_MODE     = 0;

  // strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic [REG_W-1:0] mask;
    logic [REG_W-1:0] value;
  } regStrobe_t;
endpackage

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
  import clkmode_pkg::*;
#(
  parameter logic [REG_W-1:0] PROT = PROT_MASK
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             bitOpEn,
  input  logic             bitOpSet,
  input  logic [IDX_W-1:0] bitOpIdx,
  output regStrobe_t       strobe,
  output logic             lockQ
);
  logic [REG_W-1:0] openMask;
  logic [REG_W-1:0] bitSel;
  logic             anyAccess;

  assign anyAccess = wrEn | bitOpEn;
  assign openMask  = lockQ ? ~PROT : {REG_W{1'b1}};

  always_comb begin
    bitSel           = '0;
    bitSel[bitOpIdx] = 1'b1;
  end

  // plain write wins over a bit access in the same cycle
  always_comb begin
    strobe = '0;
    if (wrEn) begin
      strobe.load  = 1'b1;
      strobe.mask  = openMask;
      strobe.value = wrData;
    end else if (bitOpEn) begin
      strobe.load  = 1'b1;
      strobe.mask  = bitSel & openMask;
      strobe.value = bitOpSet ? {REG_W{1'b1}} : {REG_W{1'b0}};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            lockQ <= 1'b0;
    else if (anyAccess) lockQ <= 1'b1;
  end
endmodule

// File: rtl/clkmode_dp.sv
module clkmode_dp
  import clkmode_pkg::*;
#(
  parameter logic [REG_W-1:0] RST_VALUE = RESET_VAL
) (
  input  logic             clk,
  input  logic             rst,
  input  regStrobe_t       strobe,
  output logic [REG_W-1:0] regQ,
  output logic [1:0]       divSel,
  output logic             mainOscOff,
  output logic             ringOscOff,
  output logic             auxBit,
  output logic             rcSel,
  output logic             dblSpeed,
  output logic             modeBit
);
  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                                regQ[i] <= RST_VALUE[i];
      else if (strobe.load && strobe.mask[i]) regQ[i] <= strobe.value[i];
    end
  end

  assign divSel     = {regQ[B_DIV_HI], regQ[B_DIV_LO]};
  assign mainOscOff = regQ[B_MAIN_OFF];
  assign ringOscOff = regQ[B_RING_OFF];
  assign auxBit     = regQ[B_AUX];
  assign rcSel      = regQ[B_SRC_RC];
  assign modeBit    = regQ[B_MODE];
  // double speed only with a ceramic source
  assign dblSpeed   = regQ[B_DBL] & ~regQ[B_SRC_RC];
endmodule

// File: rtl/clk_mode_reg.sv
module clk_mode_reg
  import clkmode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       bitOpEn,
  input  logic       bitOpSet,
  input  logic [2:0] bitOpIdx,
  output logic [7:0] rdData,
  output logic       lockStatus,
  output logic [1:0] divSel,
  output logic       mainOscOff,
  output logic       ringOscOff,
  output logic       auxBit,
  output logic       rcSel,
  output logic       dblSpeed,
  output logic       modeBit
);
  regStrobe_t strobe;

  clkmode_ctrl #(.PROT(PROT_MASK)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData),
    .bitOpEn(bitOpEn), .bitOpSet(bitOpSet), .bitOpIdx(bitOpIdx),
    .strobe(strobe), .lockQ(lockStatus)
  );

  clkmode_dp #(.RST_VALUE(RESET_VAL)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .regQ(rdData),
    .divSel(divSel), .mainOscOff(mainOscOff), .ringOscOff(ringOscOff),
    .auxBit(auxBit), .rcSel(rcSel), .dblSpeed(dblSpeed), .modeBit(modeBit)
  );
endmodule

// File: rtl/clkmode_chk.sv
module clkmode_chk (
  input logic       clk,
  input logic       rst,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic       bitOpEn,
  input logic       bitOpSet,
  input logic [2:0] bitOpIdx,
  input logic [7:0] rdData,
  input logic       lockStatus,
  input logic       dblSpeed
);
  localparam logic [7:0] PROT = 8'b0010_0011;

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (rdData == 8'h80 && !lockStatus));

  p_access_locks_r2: assert property (@(posedge clk) disable iff (rst)
    (wrEn || bitOpEn) |=> lockStatus);

  p_prot_hold_r3: assert property (@(posedge clk) disable iff (rst)
    lockStatus |=> ((rdData & PROT) == ($past(rdData) & PROT)));

  p_free_write_r3: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> ((rdData & ~PROT) == ($past(wrData) & ~PROT)));

  p_bit_op_r4: assert property (@(posedge clk) disable iff (rst)
    (bitOpEn && !wrEn && !PROT[bitOpIdx]) |=> (rdData[$past(bitOpIdx)] == $past(bitOpSet)));

  p_no_dbl_rc_r6: assert property (@(posedge clk) disable iff (rst)
    dblSpeed |-> (rdData[1] && !rdData[5]));
endmodule

bind clk_mode_reg clkmode_chk u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .bitOpEn(bitOpEn),
  .bitOpSet(bitOpSet), .bitOpIdx(bitOpIdx), .rdData(rdData),
  .lockStatus(lockStatus), .dblSpeed(dblSpeed)
);

// File: tb/sim_clk_mode_reg.sv
module sim_clk_mode_reg;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst = 1;
  logic       wrEn = 0;
  logic [7:0] wrData = 0;
  logic       bitOpEn = 0;
  logic       bitOpSet = 0;
  logic [2:0] bitOpIdx = 0;
  logic [7:0] rdData;
  logic       lockStatus;
  logic [1:0] divSel;
  logic       mainOscOff, ringOscOff, auxBit, rcSel, dblSpeed, modeBit;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  int refReg  = 'h80;
  int refLock = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_mode_reg u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .bitOpEn(bitOpEn),
    .bitOpSet(bitOpSet), .bitOpIdx(bitOpIdx), .rdData(rdData),
    .lockStatus(lockStatus), .divSel(divSel), .mainOscOff(mainOscOff),
    .ringOscOff(ringOscOff), .auxBit(auxBit), .rcSel(rcSel),
    .dblSpeed(dblSpeed), .modeBit(modeBit)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: what one edge does to register and lock
  task automatic modelEdge();
    int bitVal;
    bit isProt;
    if (rst) begin
      refReg = 'h80; refLock = 0;
    end else if (wrEn) begin
      if (refLock != 0) refReg = (refReg & 'h23) | (wrData & 'hDC);
      else              refReg = wrData;
      refLock = 1;
    end else if (bitOpEn) begin
      bitVal = 1 << bitOpIdx;
      isProt = (bitOpIdx == 5) || (bitOpIdx == 1) || (bitOpIdx == 0);
      if (!(isProt && refLock != 0)) begin
        if (bitOpSet) refReg = refReg | bitVal;
        else          refReg = refReg & ~bitVal & 'hFF;
      end
      refLock = 1;
    end
  endtask

  task automatic compareAll(input string scen);
    int rb5, rb1;
    rb5 = (refReg >> 5) & 1;
    rb1 = (refReg >> 1) & 1;
    check({scen, " R9 rdData"}, rdData, refReg);
    check({scen, " R2 lockStatus"}, lockStatus, refLock);
    check({scen, " R6 dblSpeed"}, dblSpeed, (rb1 == 1 && rb5 == 0) ? 1 : 0);
    check({scen, " R7 divSel"}, divSel, (refReg >> 6) & 3);
    check({scen, " R7 mainOscOff"}, mainOscOff, (refReg >> 4) & 1);
    check({scen, " R7 ringOscOff"}, ringOscOff, (refReg >> 3) & 1);
    check({scen, " R7 auxBit"}, auxBit, (refReg >> 2) & 1);
    check({scen, " R7 rcSel"}, rcSel, rb5);
    check({scen, " R7 modeBit"}, modeBit, refReg & 1);
  endtask

  // inputs are held from the falling edge; compare 1 time unit after the rising edge
  task automatic step(input string scen);
    @(posedge clk);
    modelEdge();
    #1;
    compareAll(scen);
    @(negedge clk);
    rst = 0; wrEn = 0; bitOpEn = 0;
  endtask

  task automatic doReset(input string scen);
    rst = 1; step(scen);
  endtask

  task automatic doWrite(input string scen, input logic [7:0] d);
    wrEn = 1; wrData = d; step(scen);
  endtask

  task automatic doBit(input string scen, input logic [2:0] idx, input logic s);
    bitOpEn = 1; bitOpIdx = idx; bitOpSet = s; step(scen);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset value 8'h80, unlocked, ring source
    doReset("R1");
    doReset("R1");
    step("R1 idle");

    // R2: first write loads all bits incl. protected, ceramic + double speed
    doWrite("R2", 8'b0100_0010);
    step("R2 idle");
    // R3: protected bits ignored, free bits load
    doWrite("R3", 8'b1011_1101);
    doWrite("R3", 8'b0000_0000);
    // R4: bit ops on free bits
    doBit("R4", 3'd2, 1'b1);
    doBit("R4", 3'd6, 1'b1);
    doBit("R4", 3'd7, 1'b0);
    // R5: locked bit op on protected bits ignored
    doBit("R5", 3'd5, 1'b1);
    doBit("R5", 3'd1, 1'b0);
    doBit("R5", 3'd0, 1'b1);

    // R5: unlocked bit op on protected bit changes it and locks
    doReset("R1");
    doBit("R5", 3'd1, 1'b1);
    doWrite("R3", 8'b0010_0001);
    doBit("R5", 3'd5, 1'b1);

    // R6: RC with double speed bit -> no double speed
    doReset("R1");
    doWrite("R6", 8'b0010_0010);
    doWrite("R6", 8'b1101_1100);

    // R8: write and bit op together; write wins
    doReset("R1");
    wrEn = 1; wrData = 8'b0001_0001; bitOpEn = 1; bitOpIdx = 3'd3; bitOpSet = 1'b1;
    step("R8");

    // R4: bit op on free bit locks protected set
    doReset("R1");
    doBit("R4", 3'd3, 1'b1);
    doWrite("R4 then R3", 8'b0010_0011);
    doBit("R4", 3'd4, 1'b1);

    // reset in mid-run clears the lock
    doReset("R1");
    doWrite("R2", 8'b0000_0011);

    // R9: mixed random traffic with occasional resets
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 19);
      rst      = (r == 0);
      wrEn     = (r >= 1 && r <= 6);
      bitOpEn  = (r >= 5 && r <= 12);
      wrData   = 8'($urandom_range(0, 255));
      bitOpIdx = 3'($urandom_range(0, 7));
      bitOpSet = 1'($urandom_range(0, 1));
      step("R9 mix");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule